// File: doc/BRIEF.md
# Dual-Role SPI Engine for a USART

This block is the synchronous serial core of a USART that can be switched into SPI operation. A 4-bit mode code selects the role. Code 0xE makes the port an SPI master and code 0xF makes it an SPI slave. Every other code leaves the SPI logic inactive, so the pins stay idle for the normal USART path. The role is taken from the mode code during hardware reset and again whenever the soft reset input is high. A change to the mode code at any other time has no effect until the next soft reset. This means a transfer in progress always finishes with the mapping it started with.

The USART pins change their use with the role:

- **Master:** the transmit pin carries MOSI, the receive pin samples MISO, the clock pin is driven as SCK, and the request-to-send pin is the single active-low slave select. SCK is built from an internal half-period divider.
- **Slave:** the receive pin samples MOSI and the transmit pin drives MISO. SCK and the select come in on the clock and clear-to-send pins, and both pass through synchronisers. The MISO driver is enabled only while the slave is selected.

Characters are 8 bits, sent MSB first, in SPI mode 0: data is sampled on the rising SCK edge and changed on the falling edge.

Top module: `usart_spi_core`

## Requirements
- R1: With a mode code other than 0xE or 0xF in force, the outputs stay idle whatever the other inputs do: `txd_oe`=0, `sck_oe`=0, `sck_o`=0, `rts_o`=1, `busy`=0, and `rx_valid` stays 0.
- R2: The role is loaded from `mode_code` only while `rst` or `soft_rst` is high; a change of `mode_code` at any other time, including during a transfer, leaves the current role and transfer unchanged.
- R3: In master role, `txd_oe`=1 and `sck_oe`=1, `rts_o` is the active-low select, and MISO is sampled from `rxd_i`.
- R4: In master role, `tx_start` starts a transfer only when `clk_src`≠3 and `clk_out_en`=1; otherwise it is ignored and `rts_o` stays 1.
- R5: Let H = `baud_div`+1 cycles, and count from the clock edge that samples `tx_start` (tick k is at H·k cycles). `rts_o` goes low at that edge. `sck_o` is high exactly during ticks 2,4,…,16, which is 8 full cycles. `busy` is high until tick 19.
- R6: The master places the byte MSB first on `txd_o` from the start edge, moves to the next bit on each falling SCK edge except the last, and samples `rxd_i` at each rising edge. `rx_data` equals the received byte, MSB first.
- R7: At tick 19 (two half periods after the last falling edge) the master raises `rts_o` with SCK low, and `rx_valid` pulses for exactly one cycle.
- R8: In slave role, with `cts_i` low, `rxd_i` is sampled at each rising `sck_i` edge, MSB first; after the 8th rising edge `rx_data` holds the byte and `rx_valid` pulses once.
- R9: In slave role, `txd_o` shows the byte most recently written with `tx_start`, MSB first, and moves to the next bit on each falling `sck_i` edge; after every 8 bits the same buffered byte is loaded again.
- R10: In slave role, `txd_oe` is 0 while `cts_i` is high and 1 while it is low, after the synchroniser delay.
- R11: While `soft_rst` is high, any transfer is abandoned: `sck_o`=0, `rts_o`=1, `busy`=0 and `rx_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| soft_rst | input | 1 | Transmitter/receiver reset; reloads the role |
| mode_code | input | 4 | Mode field (0xE master, 0xF slave) |
| clk_src | input | 2 | Clock source select (3 = external, not allowed for master) |
| clk_out_en | input | 1 | Clock output enable, must be 1 for master |
| baud_div | input | DIV_W | Half-period divider minus one |
| tx_data | input | DATA_W | Byte to send |
| tx_start | input | 1 | Master: start transfer; slave: load transmit buffer |
| rx_data | output | DATA_W | Last received byte |
| rx_valid | output | 1 | One-cycle pulse when a byte is received |
| busy | output | 1 | Master transfer in progress |
| txd_o | output | 1 | Transmit pin (MOSI or MISO) |
| txd_oe | output | 1 | Transmit pin driver enable |
| rxd_i | input | 1 | Receive pin (MISO or MOSI) |
| sck_o | output | 1 | Serial clock out (master) |
| sck_oe | output | 1 | Serial clock driver enable |
| sck_i | input | 1 | Serial clock in (slave) |
| rts_o | output | 1 | Slave select out, active low (master) |
| cts_i | input | 1 | Slave select in, active low (slave) |

## Verification
Some behaviours are checked on every cycle by assertions:

- SCK is never high while the master select is released.
- A received byte never gives `rx_valid` for two cycles in a row.
- The role never changes without a reset.
- A refused start never pulls the select low.
- The unselected slave never drives MISO.

Other behaviours can only be shown by the bench's scenarios, which compare every master cycle with a timeline model:

- The exact tick schedule of SCK and select against `baud_div`.
- MSB-first data on both lines.
- The mapping held through a mode change in the middle of a transfer.
- The slave reloading its buffer for back-to-back bytes.
- A transfer abandoned under soft reset.

// File: rtl/spi_pkg.sv
package spi_pkg;
  typedef enum logic [1:0] {
    ROLE_NONE   = 2'd0,
    ROLE_MASTER = 2'd1,
    ROLE_SLAVE  = 2'd2
  } spi_role_e;

  localparam logic [3:0] MODE_CODE_MASTER = 4'hE;
  localparam logic [3:0] MODE_CODE_SLAVE  = 4'hF;
  localparam logic [1:0] CLK_SRC_EXT      = 2'd3;

  function automatic spi_role_e decode_role(input logic [3:0] code);
    if (code == MODE_CODE_MASTER)     return ROLE_MASTER;
    else if (code == MODE_CODE_SLAVE) return ROLE_SLAVE;
    else                              return ROLE_NONE;
  endfunction
endpackage

// File: rtl/spi_role_ctl.sv
module spi_role_ctl
  import spi_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       soft_rst,
  input  logic [3:0] mode_code,
  output spi_role_e  role
);
  always_ff @(posedge clk) begin
    if (rst || soft_rst) role <= decode_role(mode_code);
  end

  // R2
  role_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !soft_rst |=> $stable(role));
endmodule

// File: rtl/spi_baud.sv
module spi_baud #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == div);

  always_ff @(posedge clk) begin
    if (clr || !run) cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/spi_master_fsm.sv
module spi_master_fsm #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              en,
  input  logic [DIV_W-1:0]  baud_div,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_start,
  input  logic              miso,
  output logic              mosi,
  output logic              sck,
  output logic              ss_n,
  output logic              busy,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  typedef enum logic [1:0] {M_IDLE, M_SETUP, M_XFER, M_HOLD} mstate_e;

  mstate_e           state;
  logic [DATA_W-1:0] tx_sh;
  logic [DATA_W-1:0] rx_sh;
  logic [CNT_W-1:0]  bit_cnt;
  logic              hold_half;
  logic              tick;

  spi_baud #(.DIV_W(DIV_W)) u_baud (
    .clk  (clk),
    .clr  (clr),
    .run  (state != M_IDLE),
    .div  (baud_div),
    .tick (tick)
  );

  assign mosi = tx_sh[DATA_W-1];
  assign busy = (state != M_IDLE);

  always_ff @(posedge clk) begin
    if (clr) begin
      state     <= M_IDLE;
      tx_sh     <= '0;
      rx_sh     <= '0;
      bit_cnt   <= '0;
      hold_half <= 1'b0;
      sck       <= 1'b0;
      ss_n      <= 1'b1;
      rx_data   <= '0;
      rx_valid  <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      case (state)
        M_IDLE: begin
          if (tx_start && en) begin
            tx_sh   <= tx_data;
            bit_cnt <= '0;
            ss_n    <= 1'b0;
            state   <= M_SETUP;
          end
        end
        M_SETUP: if (tick) state <= M_XFER;
        M_XFER: begin
          if (tick) begin
            if (!sck) begin
              sck   <= 1'b1;
              rx_sh <= {rx_sh[DATA_W-2:0], miso};
            end else begin
              sck <= 1'b0;
              if (bit_cnt == LAST_BIT) begin
                hold_half <= 1'b0;
                state     <= M_HOLD;
              end else begin
                bit_cnt <= bit_cnt + 1'b1;
                tx_sh   <= {tx_sh[DATA_W-2:0], 1'b0};
              end
            end
          end
        end
        M_HOLD: begin
          if (tick) begin
            if (!hold_half) hold_half <= 1'b1;
            else begin
              ss_n     <= 1'b1;
              rx_data  <= rx_sh;
              rx_valid <= 1'b1;
              state    <= M_IDLE;
            end
          end
        end
        default: state <= M_IDLE;
      endcase
    end
  end

  // R7
  sck_inside_select_chk: assert property (@(posedge clk) disable iff (rst)
    sck |-> !ss_n);

  // R7
  master_valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  // R4
  refused_start_chk: assert property (@(posedge clk) disable iff (rst)
    (!en && !busy && !clr) |=> ss_n);

  // R11
  soft_reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!sck && ss_n && !busy && !rx_valid));
endmodule

// File: rtl/spi_slave_shift.sv
module spi_slave_shift #(
  parameter int DATA_W = 8,
  parameter int SYNC   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_start,
  input  logic              sck_pin,
  input  logic              ss_n_pin,
  input  logic              mosi_pin,
  output logic              miso,
  output logic              miso_oe,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic [SYNC-1:0]   sck_p, ss_p, mosi_p;
  logic              sck_s, ss_s, mosi_s, sck_d;
  logic              rise, fall;
  logic [DATA_W-1:0] tx_buf, tx_sh, rx_sh;
  logic [CNT_W-1:0]  bit_cnt;

  assign sck_s  = sck_p[SYNC-1];
  assign ss_s   = ss_p[SYNC-1];
  assign mosi_s = mosi_p[SYNC-1];
  assign rise   = sck_s && !sck_d && !ss_s;
  assign fall   = !sck_s && sck_d && !ss_s;
  assign miso   = tx_sh[DATA_W-1];

  generate
    if (SYNC == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (clr) begin
          sck_p <= '0; ss_p <= '1; mosi_p <= '0;
        end else begin
          sck_p <= sck_pin; ss_p <= ss_n_pin; mosi_p <= mosi_pin;
        end
      end
    end else begin : g_syncn
      always_ff @(posedge clk) begin
        if (clr) begin
          sck_p <= '0; ss_p <= '1; mosi_p <= '0;
        end else begin
          sck_p  <= {sck_p[SYNC-2:0], sck_pin};
          ss_p   <= {ss_p[SYNC-2:0], ss_n_pin};
          mosi_p <= {mosi_p[SYNC-2:0], mosi_pin};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (clr) begin
      sck_d    <= 1'b0;
      tx_buf   <= '0;
      tx_sh    <= '0;
      rx_sh    <= '0;
      bit_cnt  <= '0;
      miso_oe  <= 1'b0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else begin
      sck_d    <= sck_s;
      rx_valid <= 1'b0;
      miso_oe  <= !ss_s;
      if (tx_start) tx_buf <= tx_data;
      if (ss_s) begin
        bit_cnt <= '0;
        tx_sh   <= tx_start ? tx_data : tx_buf;
      end else if (rise) begin
        rx_sh <= {rx_sh[DATA_W-2:0], mosi_s};
        if (bit_cnt == LAST_BIT) begin
          bit_cnt  <= '0;
          rx_data  <= {rx_sh[DATA_W-2:0], mosi_s};
          rx_valid <= 1'b1;
          tx_sh    <= tx_buf;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end else if (fall && bit_cnt != '0) begin
        tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
      end
    end
  end

  // R10
  slave_tristate_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && !$past(clr) && $past(ss_s)) |-> !miso_oe);

  // R8
  slave_valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);
endmodule

// File: rtl/usart_spi_core.sv
module usart_spi_core
  import spi_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8,
  parameter int SYNC   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic [3:0]        mode_code,
  input  logic [1:0]        clk_src,
  input  logic              clk_out_en,
  input  logic [DIV_W-1:0]  baud_div,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_start,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              busy,
  output logic              txd_o,
  output logic              txd_oe,
  input  logic              rxd_i,
  output logic              sck_o,
  output logic              sck_oe,
  input  logic              sck_i,
  output logic              rts_o,
  input  logic              cts_i
);
  spi_role_e         role;
  logic              is_m, is_s, m_en;
  logic              m_mosi, m_sck, m_ss_n, m_busy, m_valid;
  logic [DATA_W-1:0] m_rx;
  logic              s_miso, s_oe, s_valid;
  logic [DATA_W-1:0] s_rx;

  spi_role_ctl u_role (
    .clk       (clk),
    .rst       (rst),
    .soft_rst  (soft_rst),
    .mode_code (mode_code),
    .role      (role)
  );

  assign is_m = (role == ROLE_MASTER);
  assign is_s = (role == ROLE_SLAVE);
  assign m_en = is_m && (clk_src != CLK_SRC_EXT) && clk_out_en;

  spi_master_fsm #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_master (
    .clk      (clk),
    .rst      (rst),
    .clr      (rst || soft_rst || !is_m),
    .en       (m_en),
    .baud_div (baud_div),
    .tx_data  (tx_data),
    .tx_start (tx_start),
    .miso     (rxd_i),
    .mosi     (m_mosi),
    .sck      (m_sck),
    .ss_n     (m_ss_n),
    .busy     (m_busy),
    .rx_data  (m_rx),
    .rx_valid (m_valid)
  );

  spi_slave_shift #(.DATA_W(DATA_W), .SYNC(SYNC)) u_slave (
    .clk      (clk),
    .rst      (rst),
    .clr      (rst || soft_rst || !is_s),
    .tx_data  (tx_data),
    .tx_start (tx_start),
    .sck_pin  (sck_i),
    .ss_n_pin (cts_i),
    .mosi_pin (rxd_i),
    .miso     (s_miso),
    .miso_oe  (s_oe),
    .rx_data  (s_rx),
    .rx_valid (s_valid)
  );

  always_comb begin
    txd_o    = 1'b1;
    txd_oe   = 1'b0;
    sck_o    = 1'b0;
    sck_oe   = 1'b0;
    rts_o    = 1'b1;
    rx_data  = '0;
    rx_valid = 1'b0;
    busy     = 1'b0;
    if (is_m) begin
      txd_o    = m_mosi;
      txd_oe   = 1'b1;
      sck_o    = m_sck;
      sck_oe   = 1'b1;
      rts_o    = m_ss_n;
      rx_data  = m_rx;
      rx_valid = m_valid;
      busy     = m_busy;
    end else if (is_s) begin
      txd_o    = s_miso;
      txd_oe   = s_oe;
      rx_data  = s_rx;
      rx_valid = s_valid;
    end
  end

  // R1
  inactive_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!is_m && !is_s) |-> (!sck_oe && !txd_oe && rts_o && !rx_valid));
endmodule

// File: tb/usart_spi_core_tb.sv
module usart_spi_core_tb;
  localparam int DATA_W = 8;
  localparam int DIV_W  = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              soft_rst = 1'b0;
  logic [3:0]        mode_code = 4'hE;
  logic [1:0]        clk_src = 2'd0;
  logic              clk_out_en = 1'b1;
  logic [DIV_W-1:0]  baud_div = '0;
  logic [DATA_W-1:0] tx_data = '0;
  logic              tx_start = 1'b0;
  logic [DATA_W-1:0] rx_data;
  logic              rx_valid, busy, txd_o, txd_oe, sck_o, sck_oe, rts_o;
  logic              rxd_i = 1'b0;
  logic              sck_i = 1'b0;
  logic              cts_i = 1'b1;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int vcnt = 0;
  logic [DATA_W-1:0] vlast = '0;

  usart_spi_core #(.DATA_W(DATA_W), .DIV_W(DIV_W), .SYNC(2)) u_dut (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .mode_code(mode_code),
    .clk_src(clk_src), .clk_out_en(clk_out_en), .baud_div(baud_div),
    .tx_data(tx_data), .tx_start(tx_start), .rx_data(rx_data),
    .rx_valid(rx_valid), .busy(busy), .txd_o(txd_o), .txd_oe(txd_oe),
    .rxd_i(rxd_i), .sck_o(sck_o), .sck_oe(sck_oe), .sck_i(sck_i),
    .rts_o(rts_o), .cts_i(cts_i)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rx_valid) begin
      vcnt  <= vcnt + 1;
      vlast <= rx_data;
    end
  end

  always @(posedge clk) begin
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_soft(input logic [3:0] code);
    mode_code = code;
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    @(negedge clk);
  endtask

  // Timeline model of one master transfer, compared on every cycle.
  task automatic run_master(input logic [7:0] tx, input logic [7:0] miso,
                            input int div, input int flip_n, input int abort_n);
    int h, k, idx, v0;
    h = div + 1;
    baud_div = DIV_W'(div);
    v0 = vcnt;
    tx_data = tx;
    tx_start = 1'b1;
    @(negedge clk);
    tx_start = 1'b0;
    for (int n = 0; n <= 19 * h + 3; n++) begin
      k = n / h;
      idx = (k < 3) ? 0 : (((k - 1) / 2 > 7) ? 7 : (k - 1) / 2);
      if (abort_n >= 0 && n == abort_n) begin
        soft_rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R11 sck_o", sck_o, 0);
        chk("R11 rts_o", rts_o, 1);
        chk("R11 busy", busy, 0);
        chk("R11 rx_valid", rx_valid, 0);
        soft_rst = 1'b0;
        @(negedge clk);
        chk("R11 no byte delivered", vcnt, v0);
        return;
      end
      chk("R5 sck_o", sck_o, (k >= 2 && k <= 16 && k % 2 == 0) ? 1 : 0);
      chk("R5 rts_o", rts_o, (k < 19) ? 0 : 1);
      chk("R5 busy", busy, (k < 19) ? 1 : 0);
      chk("R7 rx_valid", rx_valid, (n == 19 * h) ? 1 : 0);
      if (n == 19 * h) chk("R6 rx_data", rx_data, miso);
      if (k < 19) chk("R6 txd_o", txd_o, tx[7 - idx]);
      chk("R3 txd_oe", txd_oe, 1);
      chk("R3 sck_oe", sck_oe, 1);
      if (n == flip_n) mode_code = 4'hF;
      rxd_i = miso[7 - idx];
      @(negedge clk);
    end
    chk("R7 one byte", vcnt, v0 + 1);
  endtask

  task automatic expect_idle_start(input string req, input bit master_role);
    tx_data = 8'h5A;
    tx_start = 1'b1;
    @(negedge clk);
    tx_start = 1'b0;
    for (int i = 0; i < 20; i++) begin
      chk({req, " rts_o"}, rts_o, 1);
      chk({req, " sck_o"}, sck_o, 0);
      chk({req, " busy"}, busy, 0);
      chk({req, " sck_oe"}, sck_oe, master_role ? 1 : 0);
      @(negedge clk);
    end
  endtask

  // Bench acts as master driving the slave; checks MISO before each rise.
  task automatic slave_byte(input logic [7:0] mosi, input logic [7:0] exp_miso);
    int v0;
    v0 = vcnt;
    for (int b = 7; b >= 0; b--) begin
      rxd_i = mosi[b];
      wait_cycles(8);
      chk("R9 miso bit", txd_o, exp_miso[b]);
      sck_i = 1'b1;
      wait_cycles(8);
      sck_i = 1'b0;
    end
    wait_cycles(8);
    chk("R8 rx count", vcnt, v0 + 1);
    chk("R8 rx_data", vlast, mosi);
  endtask

  initial begin
    wait_cycles(3);
    rst = 1'b0;
    @(negedge clk);
    // reset state in master role
    chk("R5 reset rts_o", rts_o, 1);
    chk("R5 reset sck_o", sck_o, 0);
    chk("R5 reset busy", busy, 0);
    chk("R7 reset rx_valid", rx_valid, 0);

    // R5/R6/R7: normal transfers, two dividers and data patterns
    run_master(8'hA5, 8'h3C, 1, -1, -1);
    run_master(8'h81, 8'hFE, 3, -1, -1);
    run_master(8'h00, 8'h01, 0, -1, -1);

    // R2: mode code changes mid-transfer, mapping kept
    run_master(8'h6B, 8'hD2, 2, 15, -1);
    chk("R2 mode_code changed", {28'd0, mode_code}, 32'hF);
    run_master(8'hC4, 8'h2F, 1, -1, -1);

    // R8/R9/R10: switch to slave by soft reset
    cts_i = 1'b1;
    sck_i = 1'b0;
    pulse_soft(4'hF);
    chk("R10 sck_oe slave", sck_oe, 0);
    chk("R10 rts_o slave", rts_o, 1);
    tx_data = 8'hA5;
    tx_start = 1'b1;
    @(negedge clk);
    tx_start = 1'b0;
    wait_cycles(5);
    chk("R10 txd_oe deselected", txd_oe, 0);
    cts_i = 1'b0;
    wait_cycles(6);
    chk("R10 txd_oe selected", txd_oe, 1);
    slave_byte(8'h3C, 8'hA5);
    slave_byte(8'hC3, 8'hA5);
    cts_i = 1'b1;
    wait_cycles(6);
    chk("R10 txd_oe released", txd_oe, 0);
    tx_data = 8'h96;
    tx_start = 1'b1;
    @(negedge clk);
    tx_start = 1'b0;
    wait_cycles(4);
    cts_i = 1'b0;
    wait_cycles(6);
    slave_byte(8'h0F, 8'h96);
    cts_i = 1'b1;
    wait_cycles(6);

    // R1: non-SPI mode code
    pulse_soft(4'h3);
    chk("R1 txd_oe", txd_oe, 0);
    chk("R1 rts_o", rts_o, 1);
    cts_i = 1'b0;
    sck_i = 1'b1;
    expect_idle_start("R1", 1'b0);
    chk("R1 txd_oe with cts low", txd_oe, 0);
    chk("R1 rx_valid", rx_valid, 0);
    cts_i = 1'b1;
    sck_i = 1'b0;

    // R4: master with bad clock configuration
    pulse_soft(4'hE);
    clk_src = 2'd3;
    expect_idle_start("R4 ext clk", 1'b1);
    clk_src = 2'd1;
    clk_out_en = 1'b0;
    expect_idle_start("R4 clko off", 1'b1);
    clk_out_en = 1'b1;
    clk_src = 2'd0;

    // R11: soft reset abandons a transfer, then recovery
    run_master(8'hF0, 8'h55, 2, -1, 25);
    run_master(8'h3A, 8'hC5, 1, -1, -1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule